// File: doc/BRIEF.md
# Interrupt Vector Entry Address Unit

This block keeps the base address of the interrupt vector table and turns an accepted interrupt into the address the processor fetches next. A control-register write port loads the base. The base can only change while the system init protection is unlocked and global interrupt enable is low. When the core accepts an interrupt, it raises a take strobe together with the 8-bit priority number of that interrupt. One cycle later the unit presents a program-counter load value and a single-cycle load pulse.

The entry address is the base OR-ed with the priority number shifted left by five. Each priority therefore owns a 32-byte slot, and slots are laid out from priority 0 upward. Because the address is an OR and not a sum, any base bit inside the slot field [12:5] would corrupt entry addresses. An accepted write that leaves any of those bits set raises a sticky warning. Several vector tables can live in code memory at once, and software switches between them by rewriting the base while interrupts are off.

Top module: `ivec_entry_unit`

## Requirements
- R1: After reset the base reads 0x0000_0000, and pcLoad, wrError, cfgWarn and pcAddr are all 0.
- R2: A write with baseWrEn=1, initUnlock=1 and intEnable=0 is accepted. baseRdData shows the written value from the next cycle on.
- R3: Bit 0 of the base always reads as 0, whatever value is written to it.
- R4: A write while initUnlock=0 is discarded. The base stays unchanged, and wrError is 1 for exactly the following cycle.
- R5: A write while intEnable=1 is discarded. The base stays unchanged, and wrError is 1 for exactly the following cycle.
- R6: pcLoad is 1 in exactly the cycle after a cycle with takeStrobe=1, and 0 in every other cycle.
- R7: When pcLoad is 1, pcAddr equals the base OR-ed with (takePrio << 5), using the base and priority sampled with the take strobe. Priority 0 gives the base itself, and priority 255 gives base | 0x1FE0.
- R8: cfgWarn sets when an accepted write leaves any of base bits [12:5] nonzero. It stays set until reset. Rejected writes never set it.
- R9: A take in any cycle after an accepted write uses the new base. A take in the same cycle as the write uses the old base.
- R10: pcAddr holds its last value in every cycle without a take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baseWrEn | input | 1 | Base register write request |
| baseWrData | input | 32 | Base register write value |
| initUnlock | input | 1 | Init protection open, writes permitted |
| intEnable | input | 1 | Global interrupt enable state |
| takeStrobe | input | 1 | Core accepts an interrupt this cycle |
| takePrio | input | 8 | Priority number of the accepted interrupt |
| pcLoad | output | 1 | One-cycle program-counter load pulse |
| pcAddr | output | 32 | Interrupt service entry address |
| wrError | output | 1 | One-cycle pulse after a rejected write |
| cfgWarn | output | 1 | Sticky warning: base bits [12:5] were left nonzero |
| baseRdData | output | 32 | Current base value, bit 0 reads 0 |

## Verification
The bound checker watches several behaviours on every cycle. It checks the one-cycle timing of pcLoad after a take, and the OR-formed address against the base and priority of the previous cycle. It also checks that the base is stable and an error pulse follows every protected write, that bit 0 reads zero, and that the warning, once set, stays set. The bench scenarios are needed for the rest. Full priority sweeps over several bases show the slot ordering and the 0x1FE0 end point. The scenarios also show a take coinciding with a write, the new base used by the following take, and the warning left clear by a rejected write carrying slot-field bits.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic wrAccept;
    logic wrReject;
    logic take;
  } ivec_strb_t;
endpackage

// File: rtl/ivec_ctrl.sv
module ivec_ctrl
  import ivec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       initUnlock,
  input  logic       intEnable,
  input  logic       takeIn,
  output ivec_strb_t strb,
  output logic       loadPulse,
  output logic       errPulse
);
  logic writePermitted;

  // Protection: init lock open and interrupts globally off
  assign writePermitted = initUnlock && !intEnable;

  always_comb begin
    strb          = '0;
    strb.wrAccept = wrEn && writePermitted;
    strb.wrReject = wrEn && !writePermitted;
    strb.take     = takeIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadPulse <= 1'b0;
      errPulse  <= 1'b0;
    end else begin
      loadPulse <= strb.take;
      errPulse  <= strb.wrReject;
    end
  end
endmodule

// File: rtl/ivec_datapath.sv
module ivec_datapath
  import ivec_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PRIO_W     = 8,
  parameter int SLOT_SHIFT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ivec_strb_t        strb,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [PRIO_W-1:0] prio,
  output logic [ADDR_W-1:0] baseQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic              warnQ
);
  localparam int FIELD_LO = SLOT_SHIFT;
  localparam int FIELD_HI = SLOT_SHIFT + PRIO_W - 1;
  localparam logic [ADDR_W-1:0] EVEN_MASK = ~{{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] prioExt;
  logic [ADDR_W-1:0] slotOffset;
  logic              fieldDirty;

  assign prioExt    = {{(ADDR_W-PRIO_W){1'b0}}, prio};
  assign slotOffset = prioExt << SLOT_SHIFT;
  assign fieldDirty = |wrData[FIELD_HI:FIELD_LO];

  // Base register, bit 0 forced to zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              baseQ <= '0;
    else if (strb.wrAccept) baseQ <= wrData & EVEN_MASK;
  end

  // Entry address: OR, not add
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          addrQ <= '0;
    else if (strb.take) addrQ <= baseQ | slotOffset;
  end

  // Sticky misconfiguration warning
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            warnQ <= 1'b0;
    else if (strb.wrAccept && fieldDirty) warnQ <= 1'b1;
  end
endmodule

// File: rtl/ivec_entry_unit.sv
module ivec_entry_unit
  import ivec_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PRIO_W     = 8,
  parameter int SLOT_SHIFT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseWrEn,
  input  logic [ADDR_W-1:0] baseWrData,
  input  logic              initUnlock,
  input  logic              intEnable,
  input  logic              takeStrobe,
  input  logic [PRIO_W-1:0] takePrio,
  output logic              pcLoad,
  output logic [ADDR_W-1:0] pcAddr,
  output logic              wrError,
  output logic              cfgWarn,
  output logic [ADDR_W-1:0] baseRdData
);
  ivec_strb_t strb;

  ivec_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (baseWrEn),
    .initUnlock(initUnlock),
    .intEnable (intEnable),
    .takeIn    (takeStrobe),
    .strb      (strb),
    .loadPulse (pcLoad),
    .errPulse  (wrError)
  );

  ivec_datapath #(
    .ADDR_W    (ADDR_W),
    .PRIO_W    (PRIO_W),
    .SLOT_SHIFT(SLOT_SHIFT)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .wrData(baseWrData),
    .prio  (takePrio),
    .baseQ (baseRdData),
    .addrQ (pcAddr),
    .warnQ (cfgWarn)
  );
endmodule

// File: rtl/ivec_entry_chk.sv
module ivec_entry_chk #(
  parameter int ADDR_W     = 32,
  parameter int PRIO_W     = 8,
  parameter int SLOT_SHIFT = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              baseWrEn,
  input logic              initUnlock,
  input logic              intEnable,
  input logic              takeStrobe,
  input logic [PRIO_W-1:0] takePrio,
  input logic              pcLoad,
  input logic [ADDR_W-1:0] pcAddr,
  input logic              wrError,
  input logic              cfgWarn,
  input logic [ADDR_W-1:0] baseRdData
);
  logic [ADDR_W-1:0] prioWide;
  assign prioWide = {{(ADDR_W-PRIO_W){1'b0}}, takePrio};

  // R3
  always_comb begin
    if (rstN) base_even_chk: assert (baseRdData[0] == 1'b0);
  end

  // R6
  load_after_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeStrobe |=> pcLoad);

  // R6
  no_spurious_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    !takeStrobe |=> !pcLoad);

  // R7
  entry_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeStrobe |=> (pcAddr == ($past(baseRdData) | ($past(prioWide) << SLOT_SHIFT))));

  // R4
  locked_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (baseWrEn && !initUnlock) |=> (wrError && $stable(baseRdData)));

  // R5
  enabled_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (baseWrEn && intEnable) |=> (wrError && $stable(baseRdData)));

  // R8
  warn_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWarn |=> cfgWarn);

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !takeStrobe |=> $stable(pcAddr));
endmodule

bind ivec_entry_unit ivec_entry_chk #(
  .ADDR_W(ADDR_W), .PRIO_W(PRIO_W), .SLOT_SHIFT(SLOT_SHIFT)
) u_chk (
  .clk(clk), .rstN(rstN), .baseWrEn(baseWrEn), .initUnlock(initUnlock),
  .intEnable(intEnable), .takeStrobe(takeStrobe), .takePrio(takePrio),
  .pcLoad(pcLoad), .pcAddr(pcAddr), .wrError(wrError), .cfgWarn(cfgWarn),
  .baseRdData(baseRdData)
);

// File: tb/ivec_entry_unit_bench.sv
module ivec_entry_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        baseWrEn = 1'b0;
  logic [31:0] baseWrData = '0;
  logic        initUnlock = 1'b0;
  logic        intEnable = 1'b0;
  logic        takeStrobe = 1'b0;
  logic [7:0]  takePrio = '0;
  logic        pcLoad;
  logic [31:0] pcAddr;
  logic        wrError;
  logic        cfgWarn;
  logic [31:0] baseRdData;

  int checks = 0;
  int errors = 0;
  logic [31:0] expBase = '0;
  logic [31:0] expAddr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ivec_entry_unit u_ivec_entry_unit (
    .clk(clk), .rstN(rstN), .baseWrEn(baseWrEn), .baseWrData(baseWrData),
    .initUnlock(initUnlock), .intEnable(intEnable), .takeStrobe(takeStrobe),
    .takePrio(takePrio), .pcLoad(pcLoad), .pcAddr(pcAddr), .wrError(wrError),
    .cfgWarn(cfgWarn), .baseRdData(baseRdData)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Drive a write at a falling edge, check at the next falling edge
  task automatic writeBase(input logic [31:0] d, input logic unl, input logic ie,
                           input string req);
    bit ok;
    @(negedge clk);
    baseWrEn = 1'b1; baseWrData = d; initUnlock = unl; intEnable = ie;
    ok = unl && !ie;
    @(negedge clk);
    baseWrEn = 1'b0; initUnlock = 1'b0; intEnable = 1'b0;
    if (ok) expBase = d & 32'hFFFF_FFFE;
    chk(baseRdData == expBase, req, baseRdData, expBase);
    chk(wrError == !ok, req, {31'd0, wrError}, {31'd0, !ok});
    @(negedge clk);
    chk(wrError == 1'b0, req, {31'd0, wrError}, 32'd0);
  endtask

  task automatic takeOne(input logic [7:0] p, input string req);
    @(negedge clk);
    takeStrobe = 1'b1; takePrio = p;
    expAddr = expBase | ({24'd0, p} << 5);
    @(negedge clk);
    takeStrobe = 1'b0;
    chk(pcLoad == 1'b1, "R6", {31'd0, pcLoad}, 32'd1);
    chk(pcAddr == expAddr, req, pcAddr, expAddr);
    @(negedge clk);
    chk(pcLoad == 1'b0, "R6", {31'd0, pcLoad}, 32'd0);
    chk(pcAddr == expAddr, "R10", pcAddr, expAddr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(baseRdData == 32'd0, "R1", baseRdData, 32'd0);
    chk(pcLoad == 1'b0 && wrError == 1'b0 && cfgWarn == 1'b0, "R1",
        {29'd0, pcLoad, wrError, cfgWarn}, 32'd0);
    chk(pcAddr == 32'd0, "R1", pcAddr, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    takeOne(8'd255, "R7 reset base");

    // R2 / R3 accepted write with bit 0 set
    writeBase(32'h8000_4001, 1'b1, 1'b0, "R2 R3");
    chk(cfgWarn == 1'b0, "R8", {31'd0, cfgWarn}, 32'd0);
    for (int p = 0; p < 256; p++) takeOne(p[7:0], "R7 sweep A");

    // R4 / R5 rejected writes
    writeBase(32'h1234_0000, 1'b0, 1'b0, "R4");
    writeBase(32'h5678_0000, 1'b1, 1'b1, "R5");
    writeBase(32'h0000_0020, 1'b1, 1'b1, "R5 R8");
    chk(cfgWarn == 1'b0, "R8 rejected", {31'd0, cfgWarn}, 32'd0);
    takeOne(8'd1, "R4 R5 base kept");

    // R8 sticky warning
    writeBase(32'hA000_0100, 1'b1, 1'b0, "R8");
    chk(cfgWarn == 1'b1, "R8 set", {31'd0, cfgWarn}, 32'd1);
    writeBase(32'hC000_0000, 1'b1, 1'b0, "R8");
    chk(cfgWarn == 1'b1, "R8 sticky", {31'd0, cfgWarn}, 32'd1);

    // R9 take together with a write uses the old base
    @(negedge clk);
    baseWrEn = 1'b1; baseWrData = 32'h9000_0000; initUnlock = 1'b1;
    takeStrobe = 1'b1; takePrio = 8'd3;
    @(negedge clk);
    baseWrEn = 1'b0; initUnlock = 1'b0; takeStrobe = 1'b0;
    chk(pcAddr == 32'hC000_0060, "R9 same cycle", pcAddr, 32'hC000_0060);
    expBase = 32'h9000_0000;
    takeOne(8'd3, "R9 next take");

    // Second table
    writeBase(32'hFFFF_E000, 1'b1, 1'b0, "R2");
    for (int p = 0; p < 256; p++) takeOne(p[7:0], "R7 sweep B");
    writeBase(32'h0000_0000, 1'b1, 1'b0, "R2");
    takeOne(8'd0, "R7 prio 0");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule